// File: doc/BRIEF.md
# Transmit Dominant Watchdog and Thermal Cutoff

This block sits between a CAN protocol controller and the analogue line driver and decides, cycle by cycle, whether the driver may push the bus dominant. A low level on the transmit data input asks for a dominant bit. The block grants that request only while the device is in normal mode and neither of two latched faults is present. The first fault is a stuck-dominant watchdog. If the controller holds the data line low for longer than a programmable number of clock cycles, the driver is released and the bus falls back to recessive. The second fault is a thermal cutoff. It is fed by the digital flag of an external over-temperature comparator.

Both faults are latched and release only through the data input itself. A stuck-dominant fault clears when the synchronized data line is seen high. A thermal fault clears at the first cycle in which the synchronized data line is high and the synchronized temperature flag is low. No timer and no register write can clear either fault. All other functions keep running while a fault is latched: the watchdog counter, the mode input and the status flags.

Both asynchronous inputs pass through two-flop synchronizers. The synchronizer on the data line resets to high, so an unconnected input reads as recessive. The synchronizer on the temperature flag resets to low. Four named states drive the controller. `ST_IDLE` means recessive is requested. `ST_DRIVE` means dominant is granted. `ST_TIMEOUT` means the stuck-dominant fault is latched. `ST_THERMAL` means the over-temperature fault is latched. The transitions are as follows:
- IDLE to DRIVE when the synchronized data is low.
- DRIVE to IDLE when the synchronized data is high.
- DRIVE to TIMEOUT when the dominant count reaches `TDOM_CYCLES`.
- TIMEOUT to IDLE when the synchronized data is high.
- Any state to THERMAL when the synchronized hot flag is high.
- THERMAL to IDLE when the synchronized data is high and the hot flag is low.

Top module: `can_tx_guard`

## Requirements
- R1: After reset the driver enable and both status flags read 0, and the internal view of the data input starts as high (recessive).
- R2: A change on `txd_in` reaches the driver enable three rising edges later (two synchronizer flops plus the state register). A low `txd_in` in normal mode with no latched fault gives `drv_en_o` = 1, and a high `txd_in` gives 0.
- R3: The dominant counter starts from zero at the cycle after the synchronized data line falls. It is held at zero whenever the synchronized line is high. It saturates at `TDOM_CYCLES` and never goes above it.
- R4: A continuous dominant request keeps `drv_en_o` high for exactly `TDOM_CYCLES` cycles. After that `drv_en_o` drops to 0 and `tmo_flag_o` rises to 1. Both stay that way for as long as the data line remains low.
- R5: A latched stuck-dominant fault clears three rising edges after `txd_in` goes high. The next low period is then timed afresh from zero.
- R6: A high `ovt_in` forces `drv_en_o` to 0 and `hot_flag_o` to 1 three rising edges later, whatever the state. The thermal fault takes priority over the stuck-dominant fault.
- R7: The thermal fault stays latched while the synchronized data line is low, even after `ovt_in` returns low. It also latches when the data line is already high. It releases at the first cycle in which the synchronized data is high and the synchronized hot flag is low.
- R8: `standby_in` = 1 forces `drv_en_o` to 0 in the same cycle. It has no effect on the state, the dominant counter or the latched faults, and `drv_en_o` follows the state again as soon as `standby_in` returns to 0.
- R9: `tmo_flag_o` and `hot_flag_o` are never high together, and `drv_en_o` is never high while either flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Transmit data from the controller, 0 = dominant request |
| ovt_in | input | 1 | Over-temperature comparator flag, 1 = too hot |
| standby_in | input | 1 | Mode select, 1 = standby, 0 = normal |
| drv_en_o | output | 1 | Line driver enable, 1 = drive dominant |
| tmo_flag_o | output | 1 | Stuck-dominant fault latched |
| hot_flag_o | output | 1 | Thermal fault latched |

## Verification
A change on `txd_in` or `ovt_in` shows up on every output three rising edges later. A change on `standby_in` acts on `drv_en_o` within the same cycle. A stuck-dominant fault appears exactly `TDOM_CYCLES` enabled cycles after the driver was first granted. The bench feeds the same input stream into a cycle model that applies this latency. Inputs are driven on the falling edge, and all three outputs are compared at the next falling edge, so each comparison lands midway between the edges. Directed checks count the enabled cycles of a stuck-low run and wait out the three-edge latency before they test a release.

// File: rtl/can_txg_pkg.sv
package can_txg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_THERMAL = 2'd3
    } txg_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/can_txg_sync.sv
module can_txg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/can_txg_domtimer.sv
module can_txg_domtimer #(
    parameter int TDOM_CYCLES = 10400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    output logic expired
);
    localparam int            CW  = $clog2(TDOM_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(TDOM_CYCLES);

    logic [CW-1:0] dom_cnt;

    // Held at zero while recessive, so each falling edge starts from zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_cnt <= '0;
        end else if (txd_s) begin
            dom_cnt <= '0;
        end else if (dom_cnt != LIM) begin
            dom_cnt <= dom_cnt + 1'b1;
        end
    end

    assign expired = (dom_cnt == LIM);

    // R3: the count never passes its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dom_cnt <= LIM);

    // R3: a recessive cycle restarts the count
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txd_s |=> (dom_cnt == '0));

endmodule

// File: rtl/can_txg_fsm.sv
module can_txg_fsm
    import can_txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    input  logic hot_s,
    input  logic tmo_hit,
    input  logic standby,
    output logic drv_en,
    output logic tmo_flag,
    output logic hot_flag
);
    txg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hot_s)       state_d = ST_THERMAL;
                else if (!txd_s) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (hot_s)        state_d = ST_THERMAL;
                else if (txd_s)   state_d = ST_IDLE;
                else if (tmo_hit) state_d = ST_TIMEOUT;
            end
            ST_TIMEOUT: begin
                if (hot_s)      state_d = ST_THERMAL;
                else if (txd_s) state_d = ST_IDLE;
            end
            ST_THERMAL: begin
                if (txd_s && !hot_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drv_en   = (state_q == ST_DRIVE) && !standby;
        tmo_flag = (state_q == ST_TIMEOUT);
        hot_flag = (state_q == ST_THERMAL);
    end

    // R6: a synchronized hot flag always lands in the thermal state
    p_hot_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hot_s |=> (state_q == ST_THERMAL));

    // R4: an expired count while still dominant latches the fault
    p_tmo_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && tmo_hit && !txd_s && !hot_s) |=> (state_q == ST_TIMEOUT));

    // R5: recessive data releases the timeout latch
    p_tmo_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMEOUT && txd_s && !hot_s) |=> (state_q == ST_IDLE));

    // R7: no release while dominant or still hot
    p_hot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THERMAL && (!txd_s || hot_s)) |=> (state_q == ST_THERMAL));

    // R9: fault flags are exclusive and block the driver
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmo_flag && hot_flag) && !(drv_en && (tmo_flag || hot_flag)));

endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
    parameter int TDOM_CYCLES = 10400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_in,
    input  logic ovt_in,
    input  logic standby_in,
    output logic drv_en_o,
    output logic tmo_flag_o,
    output logic hot_flag_o
);
    import can_txg_pkg::*;

    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_out;
    logic             tmo_hit;

    assign raw_in = {ovt_in, txd_in};

    // Index 0: data line, idles high. Index 1: hot flag, idles low.
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        can_txg_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL ((g == 0) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (raw_in[g]),
            .q_out (sync_out[g])
        );
    end

    can_txg_domtimer #(
        .TDOM_CYCLES (TDOM_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_s   (sync_out[0]),
        .expired (tmo_hit)
    );

    can_txg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_s    (sync_out[0]),
        .hot_s    (sync_out[1]),
        .tmo_hit  (tmo_hit),
        .standby  (standby_in),
        .drv_en   (drv_en_o),
        .tmo_flag (tmo_flag_o),
        .hot_flag (hot_flag_o)
    );

    // R8: standby never lets the driver on
    p_standby_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_in |-> !drv_en_o);

    // R2: a recessive request seen through the sync path drops the driver
    p_rec_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out[0] |=> !drv_en_o);

endmodule

// File: tb/can_tx_guard_tb.sv
module can_tx_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TDOM       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_in = 1'b1;
    logic ovt_in = 1'b0;
    logic standby_in = 1'b0;
    logic drv_en_o, tmo_flag_o, hot_flag_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_guard #(.TDOM_CYCLES(TDOM)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .txd_in     (txd_in),
        .ovt_in     (ovt_in),
        .standby_in (standby_in),
        .drv_en_o   (drv_en_o),
        .tmo_flag_o (tmo_flag_o),
        .hot_flag_o (hot_flag_o)
    );

    // Cycle model built from the requirements: 0 idle, 1 drive, 2 timeout, 3 thermal
    logic tx_a, tx_b, hot_a, hot_b;
    int   m_cnt, m_st;

    function automatic int next_st(int st, logic txs, logic hs, logic tmo);
        if (hs) return 3;
        case (st)
            0: return txs ? 0 : 1;
            1: return txs ? 0 : (tmo ? 2 : 1);
            2: return txs ? 0 : 2;
            default: return txs ? 0 : 3;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_a = 1'b1; tx_b = 1'b1; hot_a = 1'b0; hot_b = 1'b0;
            m_cnt = 0; m_st = 0;
        end else begin
            int n_st, n_cnt;
            n_st  = next_st(m_st, tx_b, hot_b, m_cnt == TDOM);
            n_cnt = tx_b ? 0 : ((m_cnt == TDOM) ? TDOM : m_cnt + 1);
            tx_b = tx_a;   tx_a = txd_in;
            hot_b = hot_a; hot_a = ovt_in;
            m_st = n_st; m_cnt = n_cnt;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // Wait for the falling edge and compare all outputs with the model.
    task automatic tick();
        @(negedge clk);
        chk("R2 drv_en vs model", drv_en_o, (m_st == 1) && !standby_in);
        chk("R4 tmo_flag vs model", tmo_flag_o, m_st == 2);
        chk("R6 hot_flag vs model", hot_flag_o, m_st == 3);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int en_cycles;
        void'($urandom(32'h5eed_1234));
        #(CLK_PERIOD * 3 + 1);
        @(negedge clk);
        // R1: reset state
        chk("R1 drv_en after reset", drv_en_o, 1'b0);
        chk("R1 tmo_flag after reset", tmo_flag_o, 1'b0);
        chk("R1 hot_flag after reset", hot_flag_o, 1'b0);
        rst_n = 1'b1;
        ticks(4);
        chk("R1 recessive start keeps driver off", drv_en_o, 1'b0);

        // R2: three-edge latency to dominant grant
        txd_in = 1'b0;
        tick(); tick();
        chk("R2 not yet granted after two edges", drv_en_o, 1'b0);
        tick();
        chk("R2 granted after three edges", drv_en_o, 1'b1);

        // R4 / R3: count enabled cycles of a stuck-low run
        en_cycles = 1;
        for (int i = 0; i < TDOM + 20; i++) begin
            tick();
            if (drv_en_o) en_cycles++;
        end
        chk("R4 enabled cycles equal TDOM", en_cycles == TDOM, 1'b1);
        chk("R4 timeout flag latched", tmo_flag_o, 1'b1);
        ticks(100);
        chk("R4 flag held while still low", tmo_flag_o, 1'b1);

        // R5: release and fresh timing
        txd_in = 1'b1;
        tick(); tick();
        chk("R5 flag held before latency", tmo_flag_o, 1'b1);
        tick();
        chk("R5 flag cleared", tmo_flag_o, 1'b0);
        txd_in = 1'b0;
        ticks(3 + TDOM - 1);
        chk("R5 fresh run still enabled at TDOM-1", drv_en_o, 1'b1);
        tick();
        chk("R5 fresh run times out at TDOM", tmo_flag_o, 1'b1);

        // R6: thermal over timeout priority
        ovt_in = 1'b1;
        ticks(3);
        chk("R6 thermal flag set", hot_flag_o, 1'b1);
        chk("R6 timeout flag cleared by priority", tmo_flag_o, 1'b0);
        ovt_in = 1'b0;
        ticks(10);
        chk("R7 held while data low", hot_flag_o, 1'b1);
        chk("R7 driver off while held", drv_en_o, 1'b0);
        txd_in = 1'b1;
        ticks(3);
        chk("R7 released on recessive", hot_flag_o, 1'b0);

        // R7: thermal while already recessive
        ovt_in = 1'b1;
        ticks(5);
        chk("R7 latched while high", hot_flag_o, 1'b1);
        ovt_in = 1'b0;
        txd_in = 1'b0;
        ticks(6);
        chk("R7 dominant does not release", drv_en_o, 1'b0);
        txd_in = 1'b1;
        ticks(3);
        chk("R7 release after high", hot_flag_o, 1'b0);

        // R8: standby gating without side effects
        standby_in = 1'b1;
        txd_in = 1'b0;
        ticks(10);
        chk("R8 standby keeps driver off", drv_en_o, 1'b0);
        standby_in = 1'b0;
        #1;
        chk("R8 same-cycle enable on leaving standby", drv_en_o, 1'b1);
        ticks(TDOM);
        chk("R8 timer kept running in standby", tmo_flag_o, 1'b1);
        txd_in = 1'b1;
        ticks(4);

        // Random runs
        for (int r = 0; r < 600; r++) begin
            int len;
            txd_in = ~txd_in;
            len = $urandom_range(1, 70);
            for (int k = 0; k < len; k++) begin
                if ($urandom_range(0, 99) < 2) ovt_in = ~ovt_in;
                if ($urandom_range(0, 99) < 3) standby_in = ~standby_in;
                tick();
                chk("R9 flags exclusive", tmo_flag_o & hot_flag_o, 1'b0);
            end
        end
        finish_run();
    end

endmodule